// File: doc/BRIEF.md
# Qualified Multi-Slot Instruction Queue

This block sits between a four-wide instruction dispatch bus and two decode ports. Each cycle it takes in any valid slots of the dispatch beat, packs them densely into an eight-entry circular queue, and stores each instruction word next to its three tag bits. The dispatcher sees how many entries are free and never sends more valid slots than that number.

Every queued entry has a real-valid flag that can be revoked after it is written. There are three causes. The dispatcher can cancel a slot of its previous beat. A pending branch can resolve taken, which kills every entry that was dispatched speculatively behind it. An interrupt kills every queued entry.

The queue offers the two oldest live entries to the decode ports, and the older one always goes to port 0. Revoked entries are never offered. They are removed at the head, and their space returns to the free count.

Top module: `qual_iq`

## Requirements
- R1: The instruction word (36 bits) and tag (3 bits) of a slot are delivered unchanged on a decode port.
- R2: The valid slots of one beat take consecutive entries in ascending slot order. Slots with `disp_valid` low take no entry. A beat of n accepted slots lowers `free_cnt` by n in the next cycle, apart from entries removed in that cycle.
- R3: `free_cnt` equals 8 minus the number of occupied entries. After reset it is 8 and `dec_valid` is 0. It reaches 0 when the queue is full, and the dispatcher never sends more valid slots than `free_cnt`.
- R4: If `cancel_prev[s]` is high in the cycle after a beat, the entry written from slot s of that beat is revoked. It is already hidden from the decode ports in that same cycle.
- R5: A slot with `disp_cond` set is speculative. A cycle with `br_resolve` and `br_taken` both high revokes all speculative entries and discards the speculative slots arriving in that cycle. A cycle with `br_resolve` high and `br_taken` low makes the speculative entries permanent.
- R6: While `irq` is high, no entry is offered and the incoming beat is discarded. In the next cycle the queue is empty and `free_cnt` is 8.
- R7: Revoked entries are dropped at the head without being offered. When they are dropped, their space is returned to `free_cnt`.
- R8: Port 0 carries the oldest live entry and port 1 the next oldest. `dec_valid[1]` is never high without `dec_valid[0]`.
- R9: An entry is consumed when its port's valid and ready are both high. Port 1 is consumed only when port 0 is consumed in the same cycle. An unconsumed port-0 entry stays on port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 4 | Per-slot valid of the dispatch beat |
| disp_cond | input | 4 | Per-slot flag: dispatched behind the pending branch |
| disp_instr | input | 144 | Four 36-bit instruction words, slot 0 in the low bits |
| disp_tag | input | 12 | Four 3-bit tags, slot 0 in the low bits |
| cancel_prev | input | 4 | Per-slot cancel of the previous cycle's beat |
| br_resolve | input | 1 | The pending branch resolves this cycle |
| br_taken | input | 1 | The resolving branch is taken |
| irq | input | 1 | Interrupt: flush the queue |
| free_cnt | output | 4 | Number of free entries |
| dec_valid | output | 2 | Live entry present on port 0 / port 1 |
| dec_instr | output | 72 | Port 0 word in the low 36 bits, port 1 word in the high 36 bits |
| dec_tag | output | 6 | Port 0 tag in the low 3 bits, port 1 tag in the high 3 bits |
| dec_ready | input | 2 | Per-port decoder acceptance |

## Verification
Several pairs of functions can fall in the same cycle, and the stimulus sets up each pair directly. A cancel of the last beat can arrive while that beat's entries already sit at the decode ports. The bench checks that the cancelled entry disappears from port 1 at once and that the next live entry takes its place. A taken branch can resolve in a cycle that also carries a new speculative slot. The bench judges this case through `free_cnt` and the later port contents, which must show the slot was never written. An interrupt can arrive together with a full dispatch beat and ready decoders. The outputs must offer nothing, and `free_cnt` must return to 8.

// File: rtl/qual_iq.sv
module qual_iq #(
  parameter int SLOTS = 4,
  parameter int DEPTH = 8,
  parameter int IW    = 36,
  parameter int TW    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SLOTS-1:0]      disp_valid,
  input  logic [SLOTS-1:0]      disp_cond,
  input  logic [SLOTS*IW-1:0]   disp_instr,
  input  logic [SLOTS*TW-1:0]   disp_tag,
  input  logic [SLOTS-1:0]      cancel_prev,
  input  logic                  br_resolve,
  input  logic                  br_taken,
  input  logic                  irq,
  output logic [$clog2(DEPTH+1)-1:0] free_cnt,
  output logic [1:0]            dec_valid,
  output logic [2*IW-1:0]       dec_instr,
  output logic [2*TW-1:0]       dec_tag,
  input  logic [1:0]            dec_ready
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int SW = $clog2(SLOTS+1);

  logic [IW-1:0]    q_ins [DEPTH];
  logic [TW-1:0]    q_tag [DEPTH];
  logic [DEPTH-1:0] q_rv, q_cond;
  logic [PW-1:0]    head;
  logic [CW-1:0]    cnt;
  logic [PW-1:0]    prev_ptr [SLOTS];
  logic [SLOTS-1:0] prev_wr;

  wire              kill_br = br_resolve & br_taken;
  wire [SLOTS-1:0]  slot_ok = disp_valid & ~{SLOTS{irq}} & ~({SLOTS{kill_br}} & disp_cond);

  logic [PW-1:0]    wptr [SLOTS];
  logic [SW-1:0]    n_acc;
  logic [DEPTH-1:0] eff;
  logic             f0, f1;
  logic [CW-1:0]    k0, k1, pop;
  logic [PW-1:0]    p0, p1;
  wire              take0 = f0 & dec_ready[0];
  wire              take1 = take0 & f1 & dec_ready[1];

  always_comb begin
    logic [SW-1:0] acc;
    acc = '0;
    for (int s = 0; s < SLOTS; s++) begin
      wptr[s] = head + cnt[PW-1:0] + PW'(acc);
      if (slot_ok[s]) acc = acc + 1'b1;
    end
    n_acc = acc;
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic       hit;
      logic [PW-1:0] off;
      hit = 1'b0;
      for (int s = 0; s < SLOTS; s++)
        if (prev_wr[s] && cancel_prev[s] && prev_ptr[s] == PW'(i)) hit = 1'b1;
      off = PW'(i) - head;
      eff[i] = q_rv[i] && (CW'(off) < cnt) && !hit && !(kill_br && q_cond[i]) && !irq;
    end
  end

  always_comb begin
    f0 = 1'b0; f1 = 1'b0; k0 = '0; k1 = '0; p0 = head; p1 = head;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PW-1:0] ph;
      ph = head + PW'(k);
      if (eff[ph]) begin
        if (!f0) begin f0 = 1'b1; k0 = CW'(k); p0 = ph; end
        else if (!f1) begin f1 = 1'b1; k1 = CW'(k); p1 = ph; end
      end
    end
    if (irq)        pop = cnt;
    else if (take1) pop = k1 + 1'b1;
    else if (take0) pop = k0 + 1'b1;
    else if (f0)    pop = k0;
    else            pop = cnt;
  end

  assign free_cnt  = CW'(DEPTH) - cnt;
  assign dec_valid = {f1, f0};
  assign dec_instr = {q_ins[p1], q_ins[p0]};
  assign dec_tag   = {q_tag[p1], q_tag[p0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head    <= '0;
      cnt     <= '0;
      q_rv    <= '0;
      q_cond  <= '0;
      prev_wr <= '0;
    end else begin
      q_rv <= eff;
      if (br_resolve) q_cond <= '0;
      for (int s = 0; s < SLOTS; s++)
        if (slot_ok[s]) begin
          q_rv[wptr[s]]   <= 1'b1;
          q_cond[wptr[s]] <= disp_cond[s] & ~br_resolve;
        end
      prev_wr <= slot_ok;
      head    <= head + pop[PW-1:0];
      cnt     <= cnt - pop + CW'(n_acc);
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < SLOTS; s++)
      if (slot_ok[s]) begin
        q_ins[wptr[s]] <= disp_instr[s*IW +: IW];
        q_tag[wptr[s]] <= disp_tag[s*TW +: TW];
        prev_ptr[s]    <= wptr[s];
      end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(disp_valid) <= free_cnt); // R3
  AST_FREE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CW'(DEPTH)); // R3
  AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> (free_cnt == CW'(DEPTH)) && (dec_valid == 2'b00)); // R6
  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |=> (free_cnt + CW'($past(n_acc))) >= $past(free_cnt)); // R2
  AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid[0] && !dec_ready[0] && !irq && !br_resolve && cancel_prev == '0)
    |=> dec_valid[0] && (dec_instr[IW-1:0] == $past(dec_instr[IW-1:0]))); // R9
endmodule

// File: tb/qual_iq_tb_top.sv
`timescale 1ns/1ps
module qual_iq_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   disp_valid = '0, disp_cond = '0, cancel_prev = '0;
  logic [143:0] disp_instr = '0;
  logic [11:0]  disp_tag = '0;
  logic         br_resolve = 1'b0, br_taken = 1'b0, irq = 1'b0;
  logic [1:0]   dec_ready = '0;
  logic [3:0]   free_cnt;
  logic [1:0]   dec_valid;
  logic [71:0]  dec_instr;
  logic [5:0]   dec_tag;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  qual_iq dut_i (.clk, .rst_n, .disp_valid, .disp_cond, .disp_instr, .disp_tag,
    .cancel_prev, .br_resolve, .br_taken, .irq, .free_cnt, .dec_valid,
    .dec_instr, .dec_tag, .dec_ready);

  // vld cond cancel res tk irq rdy | free dv id0 id1
  localparam logic [38:0] VEC [0:10] = '{
    {4'b1011, 4'b0000, 4'b0000, 3'b000, 2'b00, 4'd8, 2'b00, 8'd0,  8'd0 },
    {4'b0000, 4'b0000, 4'b0010, 3'b000, 2'b00, 4'd5, 2'b11, 8'd0,  8'd3 },
    {4'b1111, 4'b1100, 4'b0000, 3'b000, 2'b01, 4'd5, 2'b11, 8'd0,  8'd3 },
    {4'b0000, 4'b0000, 4'b0000, 3'b110, 2'b11, 4'd2, 2'b11, 8'd3,  8'd8 },
    {4'b1000, 4'b0000, 4'b0000, 3'b000, 2'b11, 4'd5, 2'b01, 8'd9,  8'd0 },
    {4'b0000, 4'b0000, 4'b0000, 3'b000, 2'b00, 4'd5, 2'b01, 8'd19, 8'd0 },
    {4'b0110, 4'b0110, 4'b0000, 3'b000, 2'b00, 4'd7, 2'b01, 8'd19, 8'd0 },
    {4'b0000, 4'b0000, 4'b0000, 3'b100, 2'b00, 4'd5, 2'b11, 8'd19, 8'd25},
    {4'b1000, 4'b1000, 4'b0000, 3'b110, 2'b00, 4'd5, 2'b11, 8'd19, 8'd25},
    {4'b1111, 4'b0000, 4'b0000, 3'b001, 2'b11, 4'd5, 2'b00, 8'd0,  8'd0 },
    {4'b0000, 4'b0000, 4'b0000, 3'b000, 2'b00, 4'd8, 2'b00, 8'd0,  8'd0 }
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic beat(input logic [3:0] v, input logic [3:0] c, input int base);
    disp_valid = v; disp_cond = c;
    for (int s = 0; s < 4; s++) begin
      disp_instr[s*36 +: 36] = {28'hA5A5A5A, 8'(base + s)};
      disp_tag[s*3 +: 3]     = 3'(base + s) ^ 3'b101;
    end
  endtask

  task automatic check_ports(input string req, input logic [1:0] dv, input int i0, input int i1);
    check(dec_valid == dv, {req, " dec_valid"}, dec_valid, dv);
    if (dv[0]) begin
      check(dec_instr[35:0] == {28'hA5A5A5A, 8'(i0)}, {req, " port0 word"}, dec_instr[7:0], i0);
      check(dec_tag[2:0] == (3'(i0) ^ 3'b101), "R1 port0 tag", dec_tag[2:0], 3'(i0) ^ 3'b101);
    end
    if (dv[1])
      check(dec_instr[71:36] == {28'hA5A5A5A, 8'(i1)}, {req, " port1 word"}, dec_instr[43:36], i1);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #3;
    check(free_cnt == 4'd8, "R3 reset free", free_cnt, 8);
    check(dec_valid == 2'b00, "R3 reset valid", dec_valid, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R2 R4 R5 R6 R7 R8 vector walk
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      beat(VEC[i][38:35], VEC[i][34:31], i * 4);
      cancel_prev = VEC[i][30:27];
      {br_resolve, br_taken, irq} = VEC[i][26:24];
      dec_ready = VEC[i][23:22];
      #1;
      check(free_cnt == VEC[i][21:18], $sformatf("R2 R3 free step %0d", i), free_cnt, VEC[i][21:18]);
      check_ports($sformatf("R4 R5 R6 R7 R8 step %0d", i), VEC[i][17:16], VEC[i][15:8], VEC[i][7:0]);
    end

    // fill to full, wrap, in-order drain (R3 R9 R8)
    @(negedge clk);
    beat(4'b1111, 4'b0000, 8'hC0); cancel_prev = '0; {br_resolve, br_taken, irq} = '0; dec_ready = 2'b00;
    #1 check(free_cnt == 4'd8, "R3 empty", free_cnt, 8);
    @(negedge clk);
    beat(4'b1111, 4'b0000, 8'hC4);
    #1 check(free_cnt == 4'd4, "R2 half", free_cnt, 4);
    check_ports("R8 first beat", 2'b11, 8'hC0, 8'hC1);
    @(negedge clk);
    beat(4'b0000, 4'b0000, 0); dec_ready = 2'b10;
    #1 check(free_cnt == 4'd0, "R3 full", free_cnt, 0);
    check_ports("R9 port1 only", 2'b11, 8'hC0, 8'hC1);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      dec_ready = 2'b11;
      #1 check(free_cnt == 4'(2 * j), "R9 drain free", free_cnt, 2 * j);
      check_ports("R9 R8 drain order", 2'b11, 8'hC0 + 2 * j, 8'hC1 + 2 * j);
    end
    @(negedge clk);
    dec_ready = 2'b00;
    #1 check(free_cnt == 4'd8, "R3 drained", free_cnt, 8);
    check(dec_valid == 2'b00, "R8 drained valid", dec_valid, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule